// File: doc/BRIEF.md
# Configurable-Frame Asynchronous Serial Transceiver

This block pairs an asynchronous serial transmitter and receiver that run at the same time and use one frame format, chosen at run time. The format sets the number of data bits (5 to 8), the parity (none, odd or even) and the stop length (1, 1.5 or 2 bit times). A divisor on `baudDiv` sets the bit rate. Each side runs its own oversampling tick counter at 16 ticks per bit, and that counter restarts at the start of each frame, so every bit lasts a whole number of clock cycles.

The transmit side takes a byte through a valid/ready handshake and sends it on `txd`: a low start bit, the data bits with the least-significant bit first, the optional parity bit, then the stop time at high level. The receive side passes `rxd` through a two-flop synchronizer and watches for a falling edge. It checks the line again half a bit later, and if the line is high it drops the start as a glitch. Otherwise it samples each data bit at its centre, so the first data bit is read 1.5 bit times after the edge. The received word comes out right-aligned with a one-cycle `rxValid` strobe, together with a parity-error flag and a framing-error flag.

Both sides latch the frame format when a frame begins, so changing the format pins during a frame has no effect until the next one.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, and whenever no frame is being sent, `txd` is 1, `txReady` is 1 and `rxValid` is 0.
- R2: One bit time is 16*(`baudDiv`+1) clock cycles. The start bit drives `txd` to 0 from the cycle after the accepting clock edge, for exactly one bit time.
- R3: `lenCode` selects the data length: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Data bits are sent least-significant bit first, right after the start bit.
- R4: `parCode` selects parity: 1 is odd, 2 is even, 0 and 3 mean no parity bit. When enabled, the parity bit follows the last data bit. It makes the number of ones across data and parity odd (code 1) or even (code 2).
- R5: `stopCode` selects the stop time, with `txd` held at 1: code 0 gives 1 bit time, code 1 gives 1.5 bit times (24 ticks), and codes 2 and 3 give 2 bit times.
- R6: `txReady` falls in the cycle after a frame is accepted and stays low until the last stop tick ends. `txValid` asserted while `txReady` is low is ignored.
- R7: The transmitter samples the frame format at acceptance and the receiver samples it at the start edge. Changing the format pins during a frame does not change that frame.
- R8: The receiver samples each data bit near its centre. At the centre of the first stop bit it gives a one-cycle `rxValid` pulse. `rxData` holds the word right-aligned, with unused upper bits 0.
- R9: A low pulse on `rxd` that has ended by the start-bit midpoint produces no `rxValid`, and the receiver returns to waiting for a start edge.
- R10: `rxParErr` is 1 with `rxValid` when parity is enabled and the received parity bit disagrees with the selected parity. Otherwise it is 0.
- R11: `rxFrameErr` is 1 with `rxValid` when the line is low at the centre of the first stop bit, and the data is still delivered.
- R12: `baudDiv` is 16 bits wide, so at a 250 MHz clock the divisors for 4800, 9600 and 115200 baud (3254, 1627, 135) all fit. With divisor 135 an 8-bit frame with one stop bit and no parity lasts 21760 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudDiv | input | DIV_W | Tick period minus one, in clock cycles |
| lenCode | input | 2 | Data length select (5 + code bits) |
| parCode | input | 2 | Parity select: 0/3 none, 1 odd, 2 even |
| stopCode | input | 2 | Stop select: 0 one, 1 one and a half, 2/3 two bit times |
| txValid | input | 1 | Transmit byte offered |
| txData | input | 8 | Transmit byte; upper bits beyond the length are ignored |
| txReady | output | 1 | Transmitter idle and able to accept |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rxValid | output | 1 | One-cycle strobe: received word ready |
| rxData | output | 8 | Received word, right-aligned |
| rxParErr | output | 1 | Parity mismatch on the delivered word |
| rxFrameErr | output | 1 | Stop bit found low on the delivered word |

## Verification
The bench samples every transmit bit at its centre, and it also samples one cycle on each side of the start-bit boundary and the end of the stop time. A design with the tick counter out of phase, or with the half-bit stop counted in whole bits, would shift those edges and fail there. Receive frames are sent with a flipped parity bit, with a low stop bit and as a short glitch. A receiver that trusts the first low sample would deliver a phantom word, and one that drops bad-stop data would miss its delivery. The format pins are changed in the middle of both a transmit and a receive frame, and a second `txValid` is offered while the transmitter is busy. A design that reads the pins live would change the frame's length or parity, and one that accepts while busy would send a second frame.

// File: rtl/uart_pkg.sv
package uart_pkg;

  localparam int WORD_W = 8;

  typedef enum logic [1:0] {LINE_HIGH, LINE_LOW, LINE_DATA, LINE_PAR} lineSel_e;

  typedef struct packed {
    logic [1:0] lenCode;
    logic [1:0] parCode;
  } dataCfg_t;

  typedef struct packed {
    dataCfg_t   dat;
    logic [1:0] stopCode;
  } frameCfg_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e sel;
  } txStrobe_t;

  typedef struct packed {
    logic shiftIn;
    logic capPar;
    logic deliver;
  } rxStrobe_t;

  function automatic logic [3:0] dataBits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic parOn(input logic [1:0] code);
    return (code == 2'd1) || (code == 2'd2);
  endfunction

  // parity bit for the low dataBits() bits of d under format c
  function automatic logic parBit(input logic [WORD_W-1:0] d, input dataCfg_t c);
    logic [WORD_W-1:0] masked;
    masked = d & (8'hFF >> (4'd8 - dataBits(c.lenCode)));
    return (c.parCode == 2'd1) ? ~(^masked) : (^masked);
  endfunction

endpackage

// File: rtl/uart_tick.sv
module uart_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div) && !restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= '0;
    else if (restart || cnt >= div) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txTick,
  input  logic      rxTick,
  input  logic      txValid,
  input  frameCfg_t cfgIn,
  input  logic      rxS,
  input  logic      rxFall,
  output logic      txReady,
  output logic      txRestart,
  output logic      rxRestart,
  output txStrobe_t txStb,
  output rxStrobe_t rxStb,
  output dataCfg_t  rxCfgQ
);
  localparam int PH_W = $clog2(2 * OS);
  localparam logic [PH_W-1:0] BIT_LAST  = PH_W'(OS - 1);
  localparam logic [PH_W-1:0] HALF_LAST = PH_W'(OS / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_e;

  state_e          txState, rxState;
  logic [PH_W-1:0] txPhase, rxPhase, stopLast;
  logic [2:0]      txIdx, rxIdx, txLastIdx, rxLastIdx;
  frameCfg_t       txCfgQ;
  logic            txUnitEnd, rxUnitEnd;

  assign txLastIdx = 3'(dataBits(txCfgQ.dat.lenCode) - 4'd1);
  assign rxLastIdx = 3'(dataBits(rxCfgQ.lenCode) - 4'd1);

  always_comb begin
    case (txCfgQ.stopCode)
      2'd0:    stopLast = PH_W'(OS - 1);
      2'd1:    stopLast = PH_W'(OS + OS / 2 - 1);
      default: stopLast = PH_W'(2 * OS - 1);
    endcase
  end

  // ---------------- transmit sequencing ----------------
  always_comb begin
    case (txState)
      S_START, S_DATA, S_PAR: txUnitEnd = txTick && (txPhase == BIT_LAST);
      S_STOP:                 txUnitEnd = txTick && (txPhase == stopLast);
      default:                txUnitEnd = 1'b0;
    endcase
  end

  assign txReady   = (txState == S_IDLE);
  assign txRestart = txStb.load;

  always_comb begin
    txStb.load  = txReady && txValid;
    txStb.shift = (txState == S_DATA) && txUnitEnd;
    case (txState)
      S_START: txStb.sel = LINE_LOW;
      S_DATA:  txStb.sel = LINE_DATA;
      S_PAR:   txStb.sel = LINE_PAR;
      default: txStb.sel = LINE_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= S_IDLE;
      txPhase <= '0;
      txIdx   <= '0;
      txCfgQ  <= '0;
    end else if (txState == S_IDLE) begin
      txPhase <= '0;
      txIdx   <= '0;
      if (txValid) begin
        txState <= S_START;
        txCfgQ  <= cfgIn;
      end
    end else if (txTick) begin
      txPhase <= txUnitEnd ? '0 : txPhase + 1'b1;
      if (txUnitEnd) begin
        case (txState)
          S_START: txState <= S_DATA;
          S_DATA:
            if (txIdx == txLastIdx) txState <= parOn(txCfgQ.dat.parCode) ? S_PAR : S_STOP;
            else                    txIdx   <= txIdx + 1'b1;
          S_PAR:   txState <= S_STOP;
          default: txState <= S_IDLE;
        endcase
      end
    end
  end

  // ---------------- receive sequencing ----------------
  always_comb begin
    case (rxState)
      S_START:              rxUnitEnd = rxTick && (rxPhase == HALF_LAST);
      S_DATA, S_PAR, S_STOP: rxUnitEnd = rxTick && (rxPhase == BIT_LAST);
      default:              rxUnitEnd = 1'b0;
    endcase
  end

  assign rxRestart     = (rxState == S_IDLE) && rxFall;
  assign rxStb.shiftIn = (rxState == S_DATA) && rxUnitEnd;
  assign rxStb.capPar  = (rxState == S_PAR)  && rxUnitEnd;
  assign rxStb.deliver = (rxState == S_STOP) && rxUnitEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= S_IDLE;
      rxPhase <= '0;
      rxIdx   <= '0;
      rxCfgQ  <= '0;
    end else if (rxState == S_IDLE) begin
      rxPhase <= '0;
      rxIdx   <= '0;
      if (rxFall) begin
        rxState <= S_START;
        rxCfgQ  <= cfgIn.dat;
      end
    end else if (rxTick) begin
      rxPhase <= rxUnitEnd ? '0 : rxPhase + 1'b1;
      if (rxUnitEnd) begin
        case (rxState)
          S_START: rxState <= rxS ? S_IDLE : S_DATA;
          S_DATA:
            if (rxIdx == rxLastIdx) rxState <= parOn(rxCfgQ.parCode) ? S_PAR : S_STOP;
            else                    rxIdx   <= rxIdx + 1'b1;
          S_PAR:   rxState <= S_STOP;
          default: rxState <= S_IDLE;
        endcase
      end
    end
  end

  // frame format stays frozen while a frame is in flight
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txState != S_IDLE && $past(txState) != S_IDLE) |-> $stable(txCfgQ));

  // an accepted byte makes the transmitter busy next cycle
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

endmodule

// File: rtl/uart_dp.sv
module uart_dp
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  frameCfg_t         cfgIn,
  input  logic [WORD_W-1:0] txData,
  input  txStrobe_t         txStb,
  input  dataCfg_t          rxCfgQ,
  input  rxStrobe_t         rxStb,
  input  logic              rxd,
  output logic              txd,
  output logic              rxS,
  output logic              rxFall,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  output logic              rxParErr,
  output logic              rxFrameErr
);
  logic [WORD_W-1:0] txShift, rxShift, rxAligned;
  logic              txParQ, rxParQ, rxMeta, rxPrev;

  // transmit shifter and line select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txParQ  <= 1'b0;
    end else if (txStb.load) begin
      txShift <= txData;
      txParQ  <= parBit(txData, cfgIn.dat);
    end else if (txStb.shift) begin
      txShift <= txShift >> 1;
    end
  end

  always_comb begin
    case (txStb.sel)
      LINE_LOW:  txd = 1'b0;
      LINE_DATA: txd = txShift[0];
      LINE_PAR:  txd = txParQ;
      default:   txd = 1'b1;
    endcase
  end

  // receive synchronizer and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxS    <= rxMeta;
      rxPrev <= rxS;
    end
  end

  assign rxFall    = rxPrev && !rxS;
  assign rxAligned = rxShift >> (4'd8 - dataBits(rxCfgQ.lenCode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      rxParQ     <= 1'b0;
      rxValid    <= 1'b0;
      rxData     <= '0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      rxValid <= rxStb.deliver;
      if (rxStb.shiftIn) rxShift <= {rxS, rxShift[WORD_W-1:1]};
      if (rxStb.capPar)  rxParQ  <= rxS;
      if (rxStb.deliver) begin
        rxData     <= rxAligned;
        rxParErr   <= parOn(rxCfgQ.parCode) && (rxParQ != parBit(rxAligned, rxCfgQ));
        rxFrameErr <= !rxS;
      end
    end
  end

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    txStb.load |=> !txd);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_frame_err_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxStb.deliver && !rxS) |=> (rxValid && rxFrameErr));

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [1:0]        lenCode,
  input  logic [1:0]        parCode,
  input  logic [1:0]        stopCode,
  input  logic              txValid,
  input  logic [WORD_W-1:0] txData,
  output logic              txReady,
  output logic              txd,
  input  logic              rxd,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  output logic              rxParErr,
  output logic              rxFrameErr
);
  frameCfg_t cfgIn;
  txStrobe_t txStb;
  rxStrobe_t rxStb;
  dataCfg_t  rxCfgQ;
  logic      txTick, rxTick, txRestart, rxRestart, rxS, rxFall;

  always_comb begin
    cfgIn.dat.lenCode = lenCode;
    cfgIn.dat.parCode = parCode;
    cfgIn.stopCode    = stopCode;
  end

  uart_tick #(.DIV_W(DIV_W)) uTxTick (
    .clk(clk), .rstN(rstN), .restart(txRestart), .div(baudDiv), .tick(txTick));

  uart_tick #(.DIV_W(DIV_W)) uRxTick (
    .clk(clk), .rstN(rstN), .restart(rxRestart), .div(baudDiv), .tick(rxTick));

  uart_ctrl #(.OS(OS)) uCtrl (
    .clk(clk), .rstN(rstN), .txTick(txTick), .rxTick(rxTick), .txValid(txValid),
    .cfgIn(cfgIn), .rxS(rxS), .rxFall(rxFall), .txReady(txReady),
    .txRestart(txRestart), .rxRestart(rxRestart), .txStb(txStb), .rxStb(rxStb),
    .rxCfgQ(rxCfgQ));

  uart_dp uDp (
    .clk(clk), .rstN(rstN), .cfgIn(cfgIn), .txData(txData), .txStb(txStb),
    .rxCfgQ(rxCfgQ), .rxStb(rxStb), .rxd(rxd), .txd(txd), .rxS(rxS),
    .rxFall(rxFall), .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrameErr(rxFrameErr));

endmodule

// File: tb/sim_uart_xcvr.sv
`timescale 1ns/1ps
module sim_uart_xcvr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] baudDiv = 16'd3;
  logic [1:0]  lenCode = 2'd3, parCode = 2'd0, stopCode = 2'd0;
  logic        txValid = 1'b0;
  logic [7:0]  txData = 8'h00;
  logic        txReady, txd, rxValid, rxParErr, rxFrameErr;
  logic        rxd = 1'b1;
  logic [7:0]  rxData;

  int nChk = 0, nBad = 0, B = 64, rxSeen = 0;
  logic [7:0] gotData;
  logic       gotPar, gotFrm;

  always #2 clk = ~clk;

  uart_xcvr u0 (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .lenCode(lenCode), .parCode(parCode),
    .stopCode(stopCode), .txValid(txValid), .txData(txData), .txReady(txReady),
    .txd(txd), .rxd(rxd), .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrameErr(rxFrameErr));

  always @(negedge clk) begin
    if (rxValid) begin
      rxSeen++;
      gotData = rxData;
      gotPar  = rxParErr;
      gotFrm  = rxFrameErr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  task automatic setDiv(input int d);
    baudDiv = 16'(d);
    B = 16 * (d + 1);
  endtask

  // transmit one frame and check every bit centre and the frame edges (R2-R7)
  task automatic txFrame(input logic [7:0] d, input logic [1:0] lc, input logic [1:0] pc,
                         input logic [1:0] sc, input bit chg);
    int n, nb, stopC, total;
    bit pOn;
    logic [7:0] m8;
    logic [11:0] bits;
    n = 5 + int'(lc);
    pOn = (pc == 2'd1) || (pc == 2'd2);
    m8 = d & (8'hFF >> (8 - n));
    bits = '0;
    for (int k = 0; k < n; k++) bits[k+1] = d[k];
    if (pOn) bits[n+1] = (pc == 2'd1) ? ~(^m8) : (^m8);
    nb = 1 + n + (pOn ? 1 : 0);
    stopC = (sc == 2'd0) ? B : (sc == 2'd1) ? (B * 3) / 2 : 2 * B;
    total = nb * B + stopC;
    @(negedge clk);
    lenCode = lc; parCode = pc; stopCode = sc; txData = d; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    for (int m = 0; m <= total + 4; m++) begin
      if (m > 0) @(negedge clk);
      if (chg && m == B) begin lenCode = 2'd0; parCode = 2'd2; stopCode = 2'd2; end
      if (chg && m == 2 * B) begin txValid = 1'b1; txData = 8'h00; end
      if (chg && m == 2 * B + 1) txValid = 1'b0;
      if (m == 0) check("R6 busy after accept", 32'(txReady), 32'd0);
      if (m == B - 1) check("R2 start still low", 32'(txd), 32'd0);
      for (int k = 0; k < nb; k++)
        if (m == k * B + B / 2)
          check((pOn && k == nb - 1) ? "R4 parity bit" : (k == 0 ? "R2 start bit" : "R3 data bit"),
                32'(txd), 32'(bits[k]));
      if (m == nb * B + stopC / 2) check("R5 stop level", 32'(txd), 32'd1);
      if (m == total - 1) check(chg ? "R7 frame length frozen" : "R5 stop length", 32'(txReady), 32'd0);
      if (m == total) check("R6 ready after stop", 32'(txReady), 32'd1);
      if (m == total + 4) check(chg ? "R6 busy offer ignored" : "R1 idle high", 32'(txd), 32'd1);
    end
    lenCode = 2'd3; parCode = 2'd0; stopCode = 2'd0;
  endtask

  // drive one frame on rxd and check the delivered word and flags (R7-R11)
  task automatic rxFrame(input logic [7:0] d, input logic [1:0] lc, input logic [1:0] pc,
                         input logic [1:0] sc, input bit badPar, input bit badStop, input bit chg);
    int n, c0;
    bit pOn;
    logic [7:0] m8;
    logic pb;
    n = 5 + int'(lc);
    pOn = (pc == 2'd1) || (pc == 2'd2);
    m8 = d & (8'hFF >> (8 - n));
    pb = (pc == 2'd1) ? ~(^m8) : (^m8);
    if (badPar) pb = ~pb;
    @(negedge clk);
    lenCode = lc; parCode = pc; stopCode = sc;
    c0 = rxSeen;
    rxd = 1'b0;
    repeat (B) @(negedge clk);
    if (chg) begin lenCode = ~lc; parCode = (pc == 2'd1) ? 2'd2 : 2'd1; end
    for (int k = 0; k < n; k++) begin
      rxd = d[k];
      repeat (B) @(negedge clk);
    end
    if (pOn) begin
      rxd = pb;
      repeat (B) @(negedge clk);
    end
    rxd = badStop ? 1'b0 : 1'b1;
    repeat (B) @(negedge clk);
    rxd = 1'b1;
    repeat (B) @(negedge clk);
    check("R8 one delivery", 32'(rxSeen), 32'(c0 + 1));
    check(chg ? "R7 rx format frozen" : "R8 rx data", 32'(gotData), 32'(m8));
    check("R10 parity flag", 32'(gotPar), 32'(pOn && badPar));
    check("R11 framing flag", 32'(gotFrm), 32'(badStop));
    lenCode = 2'd3; parCode = 2'd0; stopCode = 2'd0;
  endtask

  task automatic rxGlitch();
    int c0;
    @(negedge clk);
    c0 = rxSeen;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * B) @(negedge clk);
    check("R9 glitch not delivered", 32'(rxSeen), 32'(c0));
    check("R9 valid low after glitch", 32'(rxValid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset txd", 32'(txd), 32'd1);
    check("R1 reset txReady", 32'(txReady), 32'd1);
    check("R1 reset rxValid", 32'(rxValid), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    setDiv(3);
    txFrame(8'hA5, 2'd3, 2'd0, 2'd0, 1'b0);
    txFrame(8'h3B, 2'd0, 2'd1, 2'd1, 1'b0);
    txFrame(8'h5C, 2'd2, 2'd2, 2'd2, 1'b0);
    txFrame(8'hC3, 2'd1, 2'd0, 2'd3, 1'b1);
    txFrame(8'h4E, 2'd3, 2'd1, 2'd0, 1'b0);
    rxFrame(8'h96, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    rxFrame(8'h2D, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
    rxFrame(8'h71, 2'd2, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0);
    rxFrame(8'hE4, 2'd3, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0);
    rxGlitch();
    rxFrame(8'h5A, 2'd1, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1);
    // R12: 115200 baud divisor at 250 MHz
    setDiv(135);
    check("R12 bit time", 32'(B * 10), 32'd21760);
    txFrame(8'h81, 2'd3, 2'd0, 2'd0, 1'b0);
    summary();
    $finish;
  end
endmodule